// File: doc/BRIEF.md
# Processor Status Word and Privilege Guard

This block keeps a 16-bit processor status word and applies the rules that separate user code from supervisor code. The status word holds five arithmetic flags, a 3-bit interrupt mask, a supervisor bit and a trace bit. Every other bit is reserved and reads as zero. Software may write the whole word or only its low condition byte, and every write carries the privilege of the requester. An ALU writes new flags, an exception-entry strobe moves the core into supervisor state, and an incoming interrupt level is compared against the mask.

The privilege state is a two-state machine with the states `PRIV_SUPER` and `PRIV_USER`. The *drop* transition goes from `PRIV_SUPER` to `PRIV_USER` when an accepted full-word write clears the supervisor bit. The *enter* transition goes from `PRIV_USER` to `PRIV_SUPER` on the exception strobe. Every other cycle holds the state. The state selects which of two physical stack-pointer registers is active. On exception entry the old word is kept on a saved-status output so that a handler can restore it later. Trace is cleared in that same update.

Outputs that depend on the current cycle's inputs (interrupt accept and trace trap) are combinational from the registered word. All word updates take effect at the next rising clock edge.

Top module: `psw_guard`

## Requirements
- R1: After reset the word reads 16'h2700: supervisor state, mask 7, trace clear, flags clear. The saved-status output reads 0 and the privilege fault is low.
- R2: Flags sit at bit 0 carry, bit 1 overflow, bit 2 zero, bit 3 negative and bit 4 extend. The mask is bits 10:8, supervisor is bit 13 and trace is bit 15. All other bits always read 0, including after writes that set them.
- R3: A low-byte write (`wr_en`=1, `wr_low_only`=1) from either privilege loads bits 4:0 from `wr_data[4:0]` and leaves bits 15:8 unchanged.
- R4: A full-word write (`wr_en`=1, `wr_low_only`=0) is accepted only when `wr_priv`=1 and the block is in `PRIV_SUPER`. It loads `wr_data` with the reserved bits forced to 0. Clearing bit 13 in such a write moves the block to `PRIV_USER`.
- R5: A full-word write that is not accepted leaves the whole word unchanged. In the next cycle, and only that cycle, it sets `priv_fault`.
- R6: `sp_sel_super` is 1 exactly when the supervisor bit is 1, which selects the supervisor stack pointer. When it is 0 the user stack pointer is selected.
- R7: On `exc_enter` the next cycle shows `saved_word` equal to the word before the strobe, supervisor set and trace clear, with the flags and mask kept. The strobe takes priority over any write or flag update in the same cycle.
- R8: From `PRIV_USER` the only way back to `PRIV_SUPER` is `exc_enter`.
- R9: `irq_accept` is 1 when `irq_level` is 7, whatever the mask. It is also 1 when `irq_level` is 1 to 6 and strictly greater than the mask. Level 0 is never accepted.
- R10: `trace_trap` equals `insn_done` AND the trace bit, in the same cycle.
- R11: `alu_flag_we` loads bits 4:0 from `alu_flags` only when neither `exc_enter`, an accepted full write nor a low-byte write occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write request to the status word |
| wr_low_only | input | 1 | 1 = write the condition byte only, 0 = write the full word |
| wr_priv | input | 1 | Privilege tag of the write, 1 = supervisor |
| wr_data | input | 16 | Write data |
| alu_flag_we | input | 1 | Flag update strobe from the ALU |
| alu_flags | input | 5 | New flags {X,N,Z,V,C} |
| exc_enter | input | 1 | Exception-entry strobe |
| irq_level | input | 3 | Incoming interrupt level, 0 = none |
| insn_done | input | 1 | Instruction completed strobe |
| status_word | output | 16 | Current status word |
| flags | output | 5 | Current flags |
| super_mode | output | 1 | Supervisor state |
| trace_on | output | 1 | Trace enable |
| irq_mask | output | 3 | Interrupt mask |
| sp_sel_super | output | 1 | Active stack pointer select, 1 = supervisor |
| irq_accept | output | 1 | Pending interrupt accepted |
| trace_trap | output | 1 | Trace trap request |
| priv_fault | output | 1 | Privilege violation pulse |
| saved_word | output | 16 | Status word captured at exception entry |

## Verification
A behavioural model in the bench follows the word, the saved status and the fault flag, and every output is compared against it each cycle. Directed sequences sweep all eight interrupt levels against all eight mask values, which separates strict from non-strict comparison and shows whether level 7 bypasses the mask. Full-word writes are tried with every combination of write tag and machine state, which shows whether the tag, the state or both gate the write. Colliding strobes (exception with a write, a write with an ALU update) pin down the priority order. A long random stretch then mixes all inputs, with exceptions kept rare so that long runs in user state occur.

// File: rtl/psw_pkg.sv
package psw_pkg;
    localparam int WORD_W  = 16;
    localparam int FLAG_W  = 5;
    localparam int LVL_W   = 3;
    localparam int MASK_LO = 8;
    localparam int BIT_S   = 13;
    localparam int BIT_T   = 15;
    localparam logic [WORD_W-1:0] IMPL_BITS  = 16'hA71F;
    localparam logic [WORD_W-1:0] RESET_WORD = 16'h2700;

    typedef enum logic [0:0] {
        PRIV_USER  = 1'b0,
        PRIV_SUPER = 1'b1
    } priv_state_t;

    typedef enum logic [1:0] {
        UPD_HOLD,
        UPD_FULL,
        UPD_LOW,
        UPD_ALU
    } upd_kind_t;
endpackage

// File: rtl/psw_priv_fsm.sv
module psw_priv_fsm
    import psw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic exc_enter,
    input  logic full_req,
    input  logic wr_priv,
    input  logic wr_s_bit,
    output logic super_mode,
    output logic sp_sel_super,
    output logic full_ok,
    output logic priv_fault
);
    priv_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= PRIV_SUPER;
            priv_fault <= 1'b0;
        end else begin
            state_q    <= state_d;
            priv_fault <= full_req && !(wr_priv && state_q == PRIV_SUPER);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PRIV_SUPER: if (!exc_enter && full_ok && !wr_s_bit) state_d = PRIV_USER;
            PRIV_USER:  if (exc_enter) state_d = PRIV_SUPER;
            default:    state_d = PRIV_SUPER;
        endcase
    end

    always_comb begin
        super_mode   = 1'b0;
        sp_sel_super = 1'b0;
        full_ok      = 1'b0;
        unique case (state_q)
            PRIV_SUPER: begin
                super_mode   = 1'b1;
                sp_sel_super = 1'b1;
                full_ok      = full_req && wr_priv && !exc_enter;
            end
            PRIV_USER: begin
                super_mode   = 1'b0;
                sp_sel_super = 1'b0;
                full_ok      = 1'b0;
            end
            default: ;
        endcase
    end

    // R7
    exc_to_super_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_enter |=> super_mode);
    // R8
    user_stays_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!super_mode && !exc_enter) |=> !super_mode);
    // R5
    fault_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_req && !super_mode) |=> priv_fault);
    // R6
    sp_follows_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_sel_super == super_mode);
endmodule

// File: rtl/psw_word_reg.sv
module psw_word_reg
    import psw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_enter,
    input  logic              full_ok,
    input  logic              low_we,
    input  logic              alu_we,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [FLAG_W-1:0] alu_flags,
    input  logic              super_mode,
    output logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] saved_word,
    output logic [FLAG_W-1:0] flags,
    output logic [LVL_W-1:0]  irq_mask,
    output logic              trace_on
);
    logic [FLAG_W-1:0] flags_q;
    logic [LVL_W-1:0]  mask_q;
    logic              trace_q;
    upd_kind_t         kind;

    always_comb begin
        word = '0;
        word[FLAG_W-1:0]              = flags_q;
        word[MASK_LO+LVL_W-1:MASK_LO] = mask_q;
        word[BIT_S]                   = super_mode;
        word[BIT_T]                   = trace_q;
    end

    always_comb begin
        if (full_ok)     kind = UPD_FULL;
        else if (low_we) kind = UPD_LOW;
        else if (alu_we) kind = UPD_ALU;
        else             kind = UPD_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q    <= RESET_WORD[FLAG_W-1:0];
            mask_q     <= RESET_WORD[MASK_LO+LVL_W-1:MASK_LO];
            trace_q    <= RESET_WORD[BIT_T];
            saved_word <= '0;
        end else if (exc_enter) begin
            saved_word <= word;
            trace_q    <= 1'b0;
        end else begin
            unique case (kind)
                UPD_FULL: begin
                    flags_q <= wr_data[FLAG_W-1:0];
                    mask_q  <= wr_data[MASK_LO+LVL_W-1:MASK_LO];
                    trace_q <= wr_data[BIT_T];
                end
                UPD_LOW:  flags_q <= wr_data[FLAG_W-1:0];
                UPD_ALU:  flags_q <= alu_flags;
                default:  ;
            endcase
        end
    end

    assign flags    = flags_q;
    assign irq_mask = mask_q;
    assign trace_on = trace_q;

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word & ~IMPL_BITS) == '0);
    // R3
    low_keeps_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_we && !exc_enter && !full_ok) |=> $stable(word[WORD_W-1:8]));
    // R7
    exc_saves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_enter |=> (saved_word == $past(word)) && !trace_on);
endmodule

// File: rtl/psw_irq_gate.sv
module psw_irq_gate #(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] irq_level,
    input  logic [LVL_W-1:0] irq_mask,
    output logic             irq_accept
);
    localparam logic [LVL_W-1:0] TOP_LVL = '1;

    always_comb begin
        if (irq_level == TOP_LVL)  irq_accept = 1'b1;
        else if (irq_level == '0)  irq_accept = 1'b0;
        else                       irq_accept = irq_level > irq_mask;
    end

    // R9
    top_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == TOP_LVL) |-> irq_accept);
    // R9
    no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == '0) |-> !irq_accept);
endmodule

// File: rtl/psw_guard.sv
module psw_guard
    import psw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_low_only,
    input  logic        wr_priv,
    input  logic [15:0] wr_data,
    input  logic        alu_flag_we,
    input  logic [4:0]  alu_flags,
    input  logic        exc_enter,
    input  logic [2:0]  irq_level,
    input  logic        insn_done,
    output logic [15:0] status_word,
    output logic [4:0]  flags,
    output logic        super_mode,
    output logic        trace_on,
    output logic [2:0]  irq_mask,
    output logic        sp_sel_super,
    output logic        irq_accept,
    output logic        trace_trap,
    output logic        priv_fault,
    output logic [15:0] saved_word
);
    logic full_req, full_ok, low_we;

    assign full_req = wr_en && !wr_low_only;
    assign low_we   = wr_en && wr_low_only;

    psw_priv_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .exc_enter    (exc_enter),
        .full_req     (full_req),
        .wr_priv      (wr_priv),
        .wr_s_bit     (wr_data[BIT_S]),
        .super_mode   (super_mode),
        .sp_sel_super (sp_sel_super),
        .full_ok      (full_ok),
        .priv_fault   (priv_fault)
    );

    psw_word_reg u_word (
        .clk        (clk),
        .rst_n      (rst_n),
        .exc_enter  (exc_enter),
        .full_ok    (full_ok),
        .low_we     (low_we),
        .alu_we     (alu_flag_we),
        .wr_data    (wr_data),
        .alu_flags  (alu_flags),
        .super_mode (super_mode),
        .word       (status_word),
        .saved_word (saved_word),
        .flags      (flags),
        .irq_mask   (irq_mask),
        .trace_on   (trace_on)
    );

    psw_irq_gate #(.LVL_W(LVL_W)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_level  (irq_level),
        .irq_mask   (irq_mask),
        .irq_accept (irq_accept)
    );

    assign trace_trap = insn_done && trace_on;

    // R10
    trace_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done && trace_on) |-> trace_trap);
    // R5
    user_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_req && !super_mode && !exc_enter && !alu_flag_we) |=> $stable(status_word));
endmodule

// File: tb/psw_guard_tb.sv
module psw_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 0, wr_low_only = 0, wr_priv = 0, alu_flag_we = 0, exc_enter = 0, insn_done = 0;
    logic [15:0] wr_data = '0;
    logic [4:0]  alu_flags = '0;
    logic [2:0]  irq_level = '0;
    logic [15:0] status_word, saved_word;
    logic [4:0]  flags;
    logic [2:0]  irq_mask;
    logic        super_mode, trace_on, sp_sel_super, irq_accept, trace_trap, priv_fault;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [15:0] m_word, m_saved;
    logic        m_fault;

    always #4 clk = ~clk;

    psw_guard u_dut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit ref_accept(input int lvl, input int mask);
        if (lvl == 7) return 1;
        if (lvl == 0) return 0;
        return lvl > mask;
    endfunction

    task automatic check_regs();
        chk("R2/R4 status_word", status_word, m_word);
        chk("R2 reserved bits", status_word & 16'h58E0, 0);
        chk("R7 saved_word", saved_word, m_saved);
        chk("R5 priv_fault", priv_fault, m_fault);
        chk("R6 sp_sel_super", sp_sel_super, m_word[13]);
        chk("R8 super_mode", super_mode, m_word[13]);
        chk("R11 flags", flags, m_word[4:0]);
        chk("R2 irq_mask", irq_mask, m_word[10:8]);
        chk("R2 trace_on", trace_on, m_word[15]);
    endtask

    task automatic step(input bit we, input bit low, input bit pv, input logic [15:0] d,
                        input bit awe, input logic [4:0] af, input bit ex,
                        input logic [2:0] lvl, input bit dn);
        wr_en = we; wr_low_only = low; wr_priv = pv; wr_data = d;
        alu_flag_we = awe; alu_flags = af; exc_enter = ex; irq_level = lvl; insn_done = dn;
        #1;
        chk("R9 irq_accept", irq_accept, ref_accept(lvl, m_word[10:8]));
        chk("R10 trace_trap", trace_trap, dn & m_word[15]);
        @(posedge clk);
        m_fault = we && !low && !(pv && m_word[13]);
        if (ex) begin
            m_saved = m_word;
            m_word  = (m_word | 16'h2000) & ~16'h8000;
        end else if (we && !low && pv && m_word[13]) begin
            m_word = d & 16'hA71F;
        end else if (we && low) begin
            m_word = (m_word & 16'hFF00) | (d & 16'h001F);
        end else if (awe) begin
            m_word = (m_word & 16'hFF00) | {11'd0, af};
        end
        @(negedge clk);
        check_regs();
    endtask

    task automatic idle();
        step(0, 0, 0, 16'h0, 0, 5'h0, 0, 3'd0, 0);
    endtask

    initial begin
        m_word = 16'h2700; m_saved = 16'h0; m_fault = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset word", status_word, 16'h2700);
        chk("R1 reset saved", saved_word, 0);
        chk("R1 reset fault", priv_fault, 0);
        check_regs();

        // R11 ALU flags, R3 low writes
        step(0, 0, 0, 16'h0, 1, 5'h15, 0, 3'd0, 0);
        step(0, 0, 0, 16'h0, 1, 5'h0A, 0, 3'd0, 0);
        step(1, 1, 0, 16'hFFFF, 0, 5'h0, 0, 3'd0, 0);   // R3 user tag, system byte kept
        step(1, 1, 1, 16'hA5E3, 1, 5'h1F, 0, 3'd0, 0);  // R11 write beats ALU

        // R4 supervisor full writes, R9 sweep of level against mask
        for (int m = 0; m < 8; m++) begin
            step(1, 0, 1, 16'h2000 | (m << 8) | 16'h50E0, 0, 5'h0, 0, 3'd0, 0);
            for (int l = 0; l < 8; l++) step(0, 0, 0, 16'h0, 0, 5'h0, 0, l[2:0], 0);
        end
        // R5 supervisor state, user tag: rejected
        step(1, 0, 0, 16'h0000, 0, 5'h0, 0, 3'd0, 0);
        idle();
        // R10 trace on
        step(1, 0, 1, 16'hA31B, 0, 5'h0, 0, 3'd0, 0);
        step(0, 0, 0, 16'h0, 0, 5'h0, 0, 3'd0, 1);
        // R7 exception with simultaneous write and ALU
        step(1, 1, 1, 16'h0007, 1, 5'h1C, 1, 3'd0, 1);
        chk("R7 saved old word", saved_word, 16'hA31B);
        // R4 drop to user
        step(1, 0, 1, 16'h8403, 0, 5'h0, 0, 3'd0, 0);
        chk("R8 in user", super_mode, 0);
        // R5 user attempts with both tags, R8 stays user
        step(1, 0, 1, 16'h2700, 0, 5'h0, 0, 3'd0, 0);
        step(1, 0, 0, 16'hFFFF, 1, 5'h11, 0, 3'd0, 1);
        idle();
        chk("R5 fault one cycle", priv_fault, 0);
        step(1, 1, 0, 16'hFFFF, 0, 5'h0, 0, 3'd5, 1);   // R3 user low write
        // R8 exception back to super
        step(0, 0, 0, 16'h0, 0, 5'h0, 1, 3'd7, 0);
        chk("R8 super after exc", super_mode, 1);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom;
            step(r[0] | r[1], r[2], r[3] | r[4], 16'($urandom), r[5],
                 5'($urandom), ($urandom % 29) == 0, 3'($urandom), r[6]);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule